// File: doc/BRIEF.md
# Microcontroller Interrupt Flag Controller

This block is the interrupt logic of a small 8-bit microcontroller core. It gathers three event sources: an external pin whose active edge is chosen by software, a one-cycle overflow pulse from an 8-bit timer, and an 8-bit input port whose pins are watched for change through a per-pin enable mask. Each source latches a sticky flag. Each flag has an enable bit beside it, and one global enable covers all of them. All of these bits sit in one control register that software reads and writes over a simple strobed register bus.

Two outputs go to the core. The interrupt request rises when the global enable is set and some flag is set with its own enable set. The core then saves its program counter and fetches from the fixed vector address, which the block presents on a port. The wake signal ignores the global enable, so a sleeping core wakes whenever an enabled flag is pending. The core pulses `irq_take` when it enters the handler, which clears the global enable, and pulses `irq_return` on return, which sets it again.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the mask register reads 0x00, the config register reads 0x01 (rising edge selected), and `irq_req` and `wake` are low.
- R2: Config register (address 2) bit 0 selects the active edge of `ext_pin`: 1 means rising, 0 means falling. An active edge sets control bit 1 (external flag) exactly three clock edges after the pin changes. This allows two synchronizer stages and one compare stage. The opposite edge has no effect.
- R3: A one-cycle `tmr_ovf` pulse sets control bit 2 (timer flag) on the next clock edge.
- R4: A change on `port_in[i]` sets control bit 0 (port flag) three edges later, but only if bit i of the mask register (address 1) is set. Changes on unmasked pins have no effect.
- R5: The port-change detector compares the synchronized port with a stored copy. That copy is refreshed only by a read of address 3. Until that read, a flag that software clears is set again on the next edge.
- R6: Flags are sticky. Only a write of the control register (address 0) changes them. If a hardware set and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_req` is high exactly when control bit 7 (global enable) is set and, for some source, both the flag and its enable are set. The flag/enable pairs are bit 0/bit 3, bit 1/bit 4 and bit 2/bit 5.
- R8: `wake` is high exactly when some flag and its matching enable are both set, whatever the global enable holds.
- R9: An `irq_take` pulse clears the global enable and an `irq_return` pulse sets it. `irq_take` wins over `irq_return` and over a bus write in the same cycle. A bus write beats `irq_return`.
- R10: `vec_addr` always carries the interrupt vector address 0x004.
- R11: Reads return the following. Address 0 gives the control register with bit 6 always 0. Address 1 gives the mask. Address 2 gives the edge select in bit 0 with the other bits 0. Address 3 gives the synchronized port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a port read refreshes the change copy) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ext_pin | input | 1 | External edge-triggered interrupt pin |
| port_in | input | 8 | Change-detect port inputs |
| tmr_ovf | input | 1 | Timer overflow pulse |
| irq_take | input | 1 | Core entered the handler |
| irq_return | input | 1 | Core returned from the handler |
| irq_req | output | 1 | Branch-to-vector request |
| wake | output | 1 | Wake from sleep |
| vec_addr | output | 13 | Interrupt vector address |

## Verification
The bench sweeps every control register value and compares `irq_req` and `wake` with the values the bit pairs imply. This catches a swapped flag/enable pairing, or a wake signal that still depends on the global enable. For both edge settings it checks the exact three-edge latency and the ignored opposite edge. A design with one synchronizer stage too many or too few, or with the polarity inverted, fails this check. It walks a single mask bit across all eight port pins, which exposes an unmasked or misindexed change detector. It also checks that a cleared port flag comes back until the port is read, and that a flag set by hardware survives a clearing write in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NSRC    = 3;
    localparam int unsigned SRC_RB  = 0;
    localparam int unsigned SRC_EXT = 1;
    localparam int unsigned SRC_TMR = 2;
    localparam int unsigned EN_OFS  = 3;
    localparam int unsigned GIE_BIT = 7;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_MASK = 2'd1,
        REG_CFG  = 2'd2,
        REG_PORT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
        hit    = rise_sel ? (level & ~prev_q) : (~level & prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (level != prev_q)) else $error("edge without change"); // R2
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_s,
    input  logic [W-1:0] pin_mask,
    input  logic         refresh,
    output logic         hit
);
    logic [W-1:0] copy_d, copy_q;

    always_comb begin
        copy_d = refresh ? port_s : copy_q;
        hit    = |((port_s ^ copy_q) & pin_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) copy_q <= '0;
        else        copy_q <= copy_d;
    end

    AST_COPY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> $stable(copy_q)) else $error("copy moved without read"); // R5
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned PC_W        = 13,
    parameter int unsigned VECTOR      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          POL_RESET   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              tmr_ovf,
    input  logic              irq_take,
    input  logic              irq_return,
    output logic              irq_req,
    output logic              wake,
    output logic [PC_W-1:0]   vec_addr
);
    localparam int unsigned SYNC_W = PORT_W + 1;

    typedef struct packed {
        logic              gie;
        logic [NSRC-1:0]   en;
        logic [NSRC-1:0]   flag;
        logic [PORT_W-1:0] mask;
        logic              pol;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0] pins_s;
    logic [PORT_W-1:0] port_s;
    logic              ext_s;
    logic              ext_hit, port_hit;
    logic [NSRC-1:0]   hw_set;
    logic              ctrl_wr, mask_wr, cfg_wr, port_rd;
    logic              pending;

    irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ext_pin, port_in}),
        .sync_out (pins_s)
    );

    assign port_s = pins_s[PORT_W-1:0];
    assign ext_s  = pins_s[PORT_W];

    irq_edge_det edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (ext_s),
        .rise_sel (st_q.pol),
        .hit      (ext_hit)
    );

    irq_port_chg #(.W(PORT_W)) chg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_s   (port_s),
        .pin_mask (st_q.mask),
        .refresh  (port_rd),
        .hit      (port_hit)
    );

    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == REG_CTRL);
        mask_wr = bus_wr && (bus_addr == REG_MASK);
        cfg_wr  = bus_wr && (bus_addr == REG_CFG);
        port_rd = bus_rd && (bus_addr == REG_PORT);

        hw_set          = '0;
        hw_set[SRC_RB]  = port_hit;
        hw_set[SRC_EXT] = ext_hit;
        hw_set[SRC_TMR] = tmr_ovf;

        st_d = st_q;
        if (ctrl_wr) begin
            st_d.flag = bus_wdata[NSRC-1:0];
            st_d.en   = bus_wdata[EN_OFS +: NSRC];
            st_d.gie  = bus_wdata[GIE_BIT];
        end
        st_d.flag = st_d.flag | hw_set;
        if (irq_return && !ctrl_wr) st_d.gie = 1'b1;
        if (irq_take)               st_d.gie = 1'b0;
        if (mask_wr) st_d.mask = bus_wdata[PORT_W-1:0];
        if (cfg_wr)  st_d.pol  = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pol <= POL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_addr))
            REG_CTRL: begin
                bus_rdata[NSRC-1:0]       = st_q.flag;
                bus_rdata[EN_OFS +: NSRC] = st_q.en;
                bus_rdata[GIE_BIT]        = st_q.gie;
            end
            REG_MASK: bus_rdata[PORT_W-1:0] = st_q.mask;
            REG_CFG:  bus_rdata[0]          = st_q.pol;
            REG_PORT: bus_rdata[PORT_W-1:0] = port_s;
            default:  bus_rdata = '0;
        endcase
    end

    assign pending  = |(st_q.flag & st_q.en);
    assign wake     = pending;
    assign irq_req  = st_q.gie & pending;
    assign vec_addr = PC_W'(VECTOR);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag)))
        else $error("flag dropped"); // R6
    AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> st_q.flag[SRC_TMR]) else $error("timer flag missed"); // R3
    AST_EXT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit |=> st_q.flag[SRC_EXT]) else $error("pin flag missed"); // R2
    AST_PORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |=> st_q.flag[SRC_RB]) else $error("port flag missed"); // R4
    AST_REQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake) else $error("request without wake"); // R8
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !st_q.gie) else $error("take kept gie"); // R9
    AST_RET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_take && !ctrl_wr) |=> st_q.gie) else $error("return missed"); // R9
endmodule

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_pin = 1'b0;
    logic [7:0]  port_in = '0;
    logic        tmr_ovf = 1'b0, irq_take = 1'b0, irq_return = 1'b0;
    logic        irq_req, wake;
    logic [12:0] vec_addr;

    int total = 0;
    int bad = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin), .port_in(port_in),
        .tmr_ovf(tmr_ovf), .irq_take(irq_take), .irq_return(irq_return),
        .irq_req(irq_req), .wake(wake), .vec_addr(vec_addr)
    );

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 vector
        rd(2'd0, rv); chk(rv, 8'h00, "R1 ctrl");
        rd(2'd1, rv); chk(rv, 8'h00, "R1 mask");
        rd(2'd2, rv); chk(rv, 8'h01, "R1 cfg");
        chk(irq_req, 0, "R1 irq_req");
        chk(wake, 0, "R1 wake");
        chk(vec_addr, 13'h004, "R10 vector");

        // R11 register readback
        wr(2'd1, 8'hA5); rd(2'd1, rv); chk(rv, 8'hA5, "R11 mask");
        wr(2'd2, 8'hFE); rd(2'd2, rv); chk(rv, 8'h00, "R11 cfg");
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h00);

        // R7 R8 sweep of every control value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            int any;
            vb = 8'(v);
            wr(2'd0, vb);
            any = |(vb[2:0] & vb[5:3]);
            chk(irq_req, vb[7] & any, "R7 irq_req");
            chk(wake, any, "R8 wake");
            rd(2'd0, rv); chk(rv, vb & 8'hBF, "R11 ctrl");
        end
        wr(2'd0, 8'h00);

        // R3 timer
        tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        rd(2'd0, rv); chk(rv, 8'h04, "R3 timer flag");
        idle(10);
        rd(2'd0, rv); chk(rv, 8'h04, "R6 sticky");
        // R6 set beats same-cycle clear
        tmr_ovf = 1'b1; wr(2'd0, 8'h00); tmr_ovf = 1'b0;
        rd(2'd0, rv); chk(rv, 8'h04, "R6 set wins");
        wr(2'd0, 8'h00);
        rd(2'd0, rv); chk(rv, 8'h00, "R6 write clears");

        // R2 external edge, both polarities
        ext_pin = 1'b1;
        idle(2); rd(2'd0, rv); chk(rv[1], 0, "R2 rise latency early");
        rd(2'd0, rv); chk(rv[1], 1, "R2 rise latency");
        wr(2'd0, 8'h00);
        ext_pin = 1'b0; idle(5);
        rd(2'd0, rv); chk(rv[1], 0, "R2 fall ignored when rising");
        wr(2'd2, 8'h00);
        ext_pin = 1'b1; idle(5);
        rd(2'd0, rv); chk(rv[1], 0, "R2 rise ignored when falling");
        ext_pin = 1'b0;
        idle(2); rd(2'd0, rv); chk(rv[1], 0, "R2 fall latency early");
        rd(2'd0, rv); chk(rv[1], 1, "R2 fall latency");
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h01);

        // R4 one mask bit walked across the port
        for (int i = 0; i < 8; i++) begin
            int j;
            j = (i + 1) % 8;
            wr(2'd1, 8'(1 << i));
            port_in[j] = ~port_in[j]; idle(5);
            rd(2'd0, rv); chk(rv[0], 0, "R4 unmasked pin ignored");
            rd(2'd3, rv); chk(rv, port_in, "R11 port read");
            port_in[i] = ~port_in[i]; idle(3);
            rd(2'd0, rv); chk(rv[0], 1, "R4 masked pin sets");
            rd(2'd3, rv);
            wr(2'd0, 8'h00);
            rd(2'd0, rv); chk(rv[0], 0, "R4 clear after refresh");
        end

        // R5 mismatch persists until port read
        wr(2'd1, 8'hFF);
        port_in[0] = ~port_in[0]; idle(3);
        wr(2'd0, 8'h00);
        rd(2'd0, rv); chk(rv[0], 1, "R5 flag returns");
        rd(2'd3, rv);
        wr(2'd0, 8'h00); idle(3);
        rd(2'd0, rv); chk(rv[0], 0, "R5 cleared after read");

        // R9 global enable control
        wr(2'd0, 8'h80);
        irq_take = 1'b1; @(negedge clk); irq_take = 1'b0;
        rd(2'd0, rv); chk(rv[7], 0, "R9 take clears");
        irq_return = 1'b1; @(negedge clk); irq_return = 1'b0;
        rd(2'd0, rv); chk(rv[7], 1, "R9 return sets");
        irq_take = 1'b1; irq_return = 1'b1; @(negedge clk);
        irq_take = 1'b0; irq_return = 1'b0;
        rd(2'd0, rv); chk(rv[7], 0, "R9 take beats return");
        irq_take = 1'b1; wr(2'd0, 8'h80); irq_take = 1'b0;
        rd(2'd0, rv); chk(rv[7], 0, "R9 take beats write");
        irq_return = 1'b1; wr(2'd0, 8'h00); irq_return = 1'b0;
        rd(2'd0, rv); chk(rv[7], 0, "R9 write beats return");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule